// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the per-processor bookkeeping that sits behind an interrupt selector. A selector outside the block presents the best pending interrupt ID and its priority. When the processor reads the acknowledge register, the block decides whether that candidate may preempt the interrupt now being serviced. If it may, the candidate becomes the running interrupt, the selector is told to clear its pending bit, and the previous running ID is saved as a back-pointer in a per-ID link table. Preemption can therefore nest to any depth.

An end-of-interrupt (EOI) write names an ID. If that ID is the running one, the running ID falls back along its link. If it is buried deeper in the nest, a small walker follows the links one entry per clock and splices the completed entry out, so completions may arrive out of order. When a completed interrupt is level-sensitive, enabled, targeted at this processor and its line is still high, the block asks the selector to mark it pending again.

Acknowledge and EOI requests use valid/ready handshakes. A request is taken on a clock edge where both valid and ready are high. The requester holds valid and its data steady until then. Ready drops for both requests while the walker is busy. The EOI ready also drops in any cycle where an acknowledge is requested, so an acknowledge always goes first. The acknowledge response, the pending-clear and the pending-set outputs are one-cycle pulses with no back-pressure, and the consumer must take them in that cycle.

Top module: `ack_eoi_tracker`

## Requirements
- R1: An accepted acknowledge is rejected when the candidate ID is 1023, when it is not below the number of implemented IDs, or when its priority is not strictly lower than the running priority. A rejected acknowledge responds with ID 1023 and leaves the running ID, the running priority and the link table unchanged, with no pending-clear pulse.
- R2: A successful acknowledge responds with the candidate ID. It makes that ID the running ID, stores the previous running ID as that ID's link, and pulses the pending-clear output with the ID.
- R3: The running priority is 0x100 whenever the running ID is 1023. Otherwise it equals the priority that the running interrupt had when it was acknowledged.
- R4: An EOI carries a 10-bit ID. It is ignored (no state change and no pending-set pulse) when the ID is at or above the number of implemented IDs, or when the running ID is 1023.
- R5: An EOI naming the running ID replaces the running ID with that ID's link and restores the matching running priority.
- R6: An EOI naming a non-running ID starts a walk from the running ID that visits one link per clock. At the first link equal to the named ID, it overwrites that link with the named ID's own link. The walk stops without change on reaching 1023. The running ID does not change during the walk.
- R7: An EOI that is not ignored pulses the pending-set output with its ID when that ID is level-sensitive, enabled, targeted and its line is high. It does not pulse when any one of these conditions is false.
- R8: While the walk is busy, both ack_ready and eoi_ready are low and no request is taken. eoi_ready is also low in any cycle where ack_valid is high.
- R9: After reset the running ID is 1023, the running priority is 0x100, every link is 1023, and no response or pulse is asserted.
- R10: Every acknowledge taken produces exactly one ack_rsp_valid pulse, in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_id | input | 10 | Best pending ID from the selector (1023 means none) |
| pend_prio | input | PRIO_W | Priority of pend_id, lower value is more urgent |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge may be taken this cycle |
| ack_rsp_valid | output | 1 | One-cycle pulse carrying the acknowledge result |
| ack_rsp_id | output | 10 | Acknowledged ID, or 1023 when rejected |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | EOI may be taken this cycle |
| eoi_id | input | 10 | ID being completed |
| lvl_high | input | N_IRQ | Current line level per ID |
| irq_enabled | input | N_IRQ | Enable per ID |
| irq_edge | input | N_IRQ | 1 = edge-sensitive, 0 = level-sensitive, per ID |
| irq_targeted | input | N_IRQ | ID is routed to this processor |
| clr_pend_valid | output | 1 | Pulse: clear pending for clr_pend_id |
| clr_pend_id | output | 10 | ID whose pending bit is cleared |
| set_pend_valid | output | 1 | Pulse: set pending for set_pend_id |
| set_pend_id | output | 10 | ID that becomes pending again |
| run_id | output | 10 | Running ID (1023 when idle) |
| run_prio | output | PRIO_W+1 | Running priority (0x100 when idle) |

## Verification
An acknowledge and an EOI can be requested in the same cycle. The bench raises both from idle, with the EOI naming the very ID being acknowledged. The expected result is that the acknowledge is served first, EOI ready stays low in that cycle, and the EOI is then taken and returns the block to idle. Had the EOI been served first, it would have been ignored and the ID would have been left running. The bench also requests an acknowledge while a chain walk is in flight. It expects no response until the walk ends and the running ID to stay unchanged throughout.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int ID_W = 10;
  typedef logic [ID_W-1:0] irq_id_t;
  localparam irq_id_t SPUR_ID = irq_id_t'(1023);
endpackage

// File: rtl/trk_link_store.sv
module trk_link_store
  import trk_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_link,
  input  logic              we_prio,
  input  irq_id_t           wa,
  input  irq_id_t           wd_link,
  input  logic [PRIO_W-1:0] wd_prio,
  input  irq_id_t           ra_a,
  output irq_id_t           rd_a,
  input  irq_id_t           ra_b,
  output irq_id_t           rd_b,
  input  irq_id_t           ra_c,
  output irq_id_t           rd_c,
  input  irq_id_t           ra_p,
  output logic [PRIO_W-1:0] rd_p
);
  localparam int      IDX_W = $clog2(N_IRQ);
  localparam irq_id_t N_ID  = irq_id_t'(N_IRQ);

  irq_id_t           link_q [N_IRQ];
  logic [PRIO_W-1:0] prio_q [N_IRQ];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[g] <= SPUR_ID;
        prio_q[g] <= '0;
      end else begin
        if (we_link && wa == irq_id_t'(g)) link_q[g] <= wd_link;
        if (we_prio && wa == irq_id_t'(g)) prio_q[g] <= wd_prio;
      end
    end
  end

  always_comb begin
    rd_a = (ra_a < N_ID) ? link_q[ra_a[IDX_W-1:0]] : SPUR_ID;
    rd_b = (ra_b < N_ID) ? link_q[ra_b[IDX_W-1:0]] : SPUR_ID;
    rd_c = (ra_c < N_ID) ? link_q[ra_c[IDX_W-1:0]] : SPUR_ID;
    rd_p = (ra_p < N_ID) ? prio_q[ra_p[IDX_W-1:0]] : '0;
  end
endmodule

// File: rtl/trk_chain_walker.sv
module trk_chain_walker
  import trk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  irq_id_t start_cur,
  input  irq_id_t start_tgt,
  output logic    busy,
  output irq_id_t lk_addr,
  input  irq_id_t lk_data,
  output irq_id_t tg_addr,
  input  irq_id_t tg_data,
  output logic    wr_en,
  output irq_id_t wr_addr,
  output irq_id_t wr_data
);
  logic    busy_q;
  irq_id_t cur_q, tgt_q;

  assign busy    = busy_q;
  assign lk_addr = cur_q;
  assign tg_addr = tgt_q;
  assign wr_en   = busy_q && (lk_data == tgt_q);
  assign wr_addr = cur_q;
  assign wr_data = tg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= SPUR_ID;
      tgt_q  <= SPUR_ID;
    end else if (start) begin
      busy_q <= 1'b1;
      cur_q  <= start_cur;
      tgt_q  <= start_tgt;
    end else if (busy_q) begin
      if (lk_data == SPUR_ID || lk_data == tgt_q) busy_q <= 1'b0;
      else cur_q <= lk_data;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R8
  AST_WALK_ON_LIVE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cur_q != SPUR_ID); // R6
endmodule

// File: rtl/ack_eoi_tracker.sv
module ack_eoi_tracker
  import trk_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              ack_rsp_valid,
  output logic [9:0]        ack_rsp_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [9:0]        eoi_id,
  input  logic [N_IRQ-1:0]  lvl_high,
  input  logic [N_IRQ-1:0]  irq_enabled,
  input  logic [N_IRQ-1:0]  irq_edge,
  input  logic [N_IRQ-1:0]  irq_targeted,
  output logic              clr_pend_valid,
  output logic [9:0]        clr_pend_id,
  output logic              set_pend_valid,
  output logic [9:0]        set_pend_id,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio
);
  localparam int                IDX_W    = $clog2(N_IRQ);
  localparam irq_id_t           N_ID     = irq_id_t'(N_IRQ);
  localparam logic [PRIO_W:0]   RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

  irq_id_t         run_id_q;
  logic [PRIO_W:0] run_prio_q;
  logic            walk_busy;

  // request acceptance
  logic ack_fire, ack_ok, eoi_fire, eoi_ok, eoi_pop, eoi_walk, repend;
  logic [IDX_W-1:0] eidx;

  assign ack_ready = !walk_busy;
  assign eoi_ready = !walk_busy && !ack_valid;
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;
  assign ack_ok    = (pend_id != SPUR_ID) && (pend_id < N_ID) &&
                     ({1'b0, pend_prio} < run_prio_q);
  assign eoi_ok    = eoi_fire && (eoi_id < N_ID) && (run_id_q != SPUR_ID);
  assign eoi_pop   = eoi_ok && (eoi_id == run_id_q);
  assign eoi_walk  = eoi_ok && (eoi_id != run_id_q);
  assign eidx      = eoi_id[IDX_W-1:0];
  assign repend    = eoi_ok && lvl_high[eidx] && irq_enabled[eidx] &&
                     !irq_edge[eidx] && irq_targeted[eidx];

  // link table and walker
  irq_id_t           pop_link, wk_lk_addr, wk_lk_data, wk_tg_addr, wk_tg_data;
  irq_id_t           wk_wr_addr, wk_wr_data;
  logic              wk_wr_en;
  logic [PRIO_W-1:0] pop_prio;

  trk_link_store #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_link ((ack_fire && ack_ok) || wk_wr_en),
    .we_prio (ack_fire && ack_ok),
    .wa      (ack_fire ? pend_id : wk_wr_addr),
    .wd_link (ack_fire ? run_id_q : wk_wr_data),
    .wd_prio (pend_prio),
    .ra_a    (run_id_q),
    .rd_a    (pop_link),
    .ra_b    (wk_lk_addr),
    .rd_b    (wk_lk_data),
    .ra_c    (wk_tg_addr),
    .rd_c    (wk_tg_data),
    .ra_p    (pop_link),
    .rd_p    (pop_prio)
  );

  trk_chain_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eoi_walk),
    .start_cur (run_id_q),
    .start_tgt (eoi_id),
    .busy      (walk_busy),
    .lk_addr   (wk_lk_addr),
    .lk_data   (wk_lk_data),
    .tg_addr   (wk_tg_addr),
    .tg_data   (wk_tg_data),
    .wr_en     (wk_wr_en),
    .wr_addr   (wk_wr_addr),
    .wr_data   (wk_wr_data)
  );

  // running state and pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q       <= SPUR_ID;
      run_prio_q     <= RUN_IDLE;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= SPUR_ID;
      clr_pend_valid <= 1'b0;
      clr_pend_id    <= SPUR_ID;
      set_pend_valid <= 1'b0;
      set_pend_id    <= SPUR_ID;
    end else begin
      if (ack_fire && ack_ok) begin
        run_id_q   <= pend_id;
        run_prio_q <= {1'b0, pend_prio};
      end else if (eoi_pop) begin
        run_id_q   <= pop_link;
        run_prio_q <= (pop_link == SPUR_ID) ? RUN_IDLE : {1'b0, pop_prio};
      end
      ack_rsp_valid  <= ack_fire;
      ack_rsp_id     <= (ack_fire && ack_ok) ? pend_id : SPUR_ID;
      clr_pend_valid <= ack_fire && ack_ok;
      clr_pend_id    <= pend_id;
      set_pend_valid <= repend;
      set_pend_id    <= eoi_id;
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    run_id_q == SPUR_ID |-> run_prio_q == RUN_IDLE); // R3
  AST_LIVE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    run_id_q != SPUR_ID |-> run_prio_q < RUN_IDLE); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !ack_ok) |=> $stable(run_id_q) && ack_rsp_id == SPUR_ID && !clr_pend_valid); // R1
  AST_RSP_IS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id != SPUR_ID) |-> run_id_q == ack_rsp_id); // R2
  AST_WALK_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> $stable(run_id_q) && !ack_rsp_valid); // R6
  AST_IGNORED_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !eoi_ok) |=> $stable(run_id_q) && !set_pend_valid); // R4
endmodule

// File: tb/sim_ack_eoi_tracker.sv
module sim_ack_eoi_tracker;
  localparam int N = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] pend_id = 10'd1023;
  logic [7:0] pend_prio = 8'd0;
  logic ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [9:0] eoi_id = 10'd0;
  logic [N-1:0] lvl_high = '0, irq_enabled = '0, irq_edge = '0, irq_targeted = '0;
  logic ack_ready, ack_rsp_valid, eoi_ready, clr_pend_valid, set_pend_valid;
  logic [9:0] ack_rsp_id, clr_pend_id, set_pend_id, run_id;
  logic [8:0] run_prio;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ack_eoi_tracker #(.N_IRQ(N), .PRIO_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_id(pend_id), .pend_prio(pend_prio),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_id(eoi_id), .lvl_high(lvl_high), .irq_enabled(irq_enabled),
    .irq_edge(irq_edge), .irq_targeted(irq_targeted),
    .clr_pend_valid(clr_pend_valid), .clr_pend_id(clr_pend_id),
    .set_pend_valid(set_pend_valid), .set_pend_id(set_pend_id),
    .run_id(run_id), .run_prio(run_prio));

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_ack(input int id, input int prio);
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(prio); ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    @(negedge clk);
    while (!eoi_ready) @(negedge clk);
    eoi_id = 10'(id); eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 run_id", int'(run_id), 1023);
    chk("R9 run_prio", int'(run_prio), 256);
    chk("R9 rsp_valid", int'(ack_rsp_valid), 0);
    chk("R9 ack_ready", int'(ack_ready), 1);
  endtask

  task automatic t_reject();
    do_ack(1023, 0);
    chk("R1 rsp for 1023", int'(ack_rsp_id), 1023);
    chk("R10 rsp pulse", int'(ack_rsp_valid), 1);
    chk("R1 run kept", int'(run_id), 1023);
    chk("R1 no clear", int'(clr_pend_valid), 0);
    do_ack(5, 8'h40);
    chk("R2 rsp id", int'(ack_rsp_id), 5);
    chk("R2 run id", int'(run_id), 5);
    chk("R3 run prio", int'(run_prio), 8'h40);
    chk("R2 clear pulse", int'(clr_pend_valid), 1);
    chk("R2 clear id", int'(clr_pend_id), 5);
    do_ack(7, 8'h40);
    chk("R1 equal prio rejected", int'(ack_rsp_id), 1023);
    chk("R1 run kept", int'(run_id), 5);
    do_ack(7, 8'h50);
    chk("R1 lower urgency rejected", int'(ack_rsp_id), 1023);
    @(negedge clk);
    chk("R10 single pulse", int'(ack_rsp_valid), 0);
  endtask

  task automatic t_nest_pop();
    do_ack(9, 8'h20);
    do_ack(12, 8'h10);
    chk("R2 nested run", int'(run_id), 12);
    do_eoi(12);
    chk("R5 pop id", int'(run_id), 9);
    chk("R5 pop prio", int'(run_prio), 8'h20);
    do_eoi(9);
    chk("R5 pop id", int'(run_id), 5);
    chk("R5 pop prio", int'(run_prio), 8'h40);
    do_eoi(5);
    chk("R3 idle id", int'(run_id), 1023);
    chk("R3 idle prio", int'(run_prio), 256);
  endtask

  task automatic t_deep_unlink();
    do_ack(5, 8'h40); do_ack(9, 8'h20); do_ack(12, 8'h10);
    @(negedge clk);
    eoi_id = 10'd5; eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    chk("R8 eoi_ready busy", int'(eoi_ready), 0);
    chk("R8 ack_ready busy", int'(ack_ready), 0);
    pend_id = 10'd30; pend_prio = 8'd0; ack_valid = 1'b1;
    @(negedge clk);
    chk("R8 no ack while busy", int'(ack_rsp_valid), 0);
    chk("R6 run held in walk", int'(run_id), 12);
    ack_valid = 1'b0;
    @(negedge clk);
    chk("R6 two-step walk ends", int'(eoi_ready), 1);
    chk("R6 run unchanged", int'(run_id), 12);
    do_eoi(12);
    chk("R6 link kept", int'(run_id), 9);
    do_eoi(9);
    chk("R6 deepest unlinked", int'(run_id), 1023);
  endtask

  task automatic t_mid_unlink();
    do_ack(5, 8'h40); do_ack(9, 8'h20); do_ack(12, 8'h10);
    do_eoi(9);
    chk("R6 busy one step", int'(eoi_ready), 0);
    @(negedge clk);
    chk("R6 walk done", int'(eoi_ready), 1);
    do_eoi(12);
    chk("R6 middle skipped", int'(run_id), 5);
    chk("R6 prio after skip", int'(run_prio), 8'h40);
    do_eoi(5);
    chk("R5 back to idle", int'(run_id), 1023);
  endtask

  task automatic t_eoi_ignored();
    lvl_high[5] = 1'b1; irq_enabled[5] = 1'b1; irq_targeted[5] = 1'b1;
    do_eoi(5);
    chk("R4 idle eoi no change", int'(run_id), 1023);
    chk("R4 idle eoi no repend", int'(set_pend_valid), 0);
    lvl_high = '0; irq_enabled = '0; irq_targeted = '0;
    do_ack(3, 8'h30);
    do_eoi(100);
    chk("R4 out of range ignored", int'(run_id), 3);
    do_eoi(1023);
    chk("R4 spurious ignored", int'(run_id), 3);
    chk("R4 prio kept", int'(run_prio), 8'h30);
    do_eoi(3);
    chk("R4 valid eoi pops", int'(run_id), 1023);
  endtask

  task automatic t_repend();
    lvl_high[20] = 1'b1; irq_enabled[20] = 1'b1; irq_targeted[20] = 1'b1;
    do_ack(20, 8'h10);
    do_eoi(20);
    chk("R7 repend pulse", int'(set_pend_valid), 1);
    chk("R7 repend id", int'(set_pend_id), 20);
    irq_edge[20] = 1'b1;
    do_ack(20, 8'h10);
    do_eoi(20);
    chk("R7 edge no repend", int'(set_pend_valid), 0);
    irq_edge[20] = 1'b0; irq_targeted[20] = 1'b0;
    do_ack(20, 8'h10);
    do_eoi(20);
    chk("R7 untargeted no repend", int'(set_pend_valid), 0);
    lvl_high = '0; irq_enabled = '0;
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    pend_id = 10'd8; pend_prio = 8'h60; ack_valid = 1'b1;
    eoi_id = 10'd8; eoi_valid = 1'b1;
    #1;
    chk("R8 eoi held by ack", int'(eoi_ready), 0);
    @(negedge clk);
    chk("R8 ack first", int'(ack_rsp_id), 8);
    chk("R8 run after ack", int'(run_id), 8);
    ack_valid = 1'b0;
    #1;
    chk("R8 eoi ready after ack", int'(eoi_ready), 1);
    @(negedge clk);
    eoi_valid = 1'b0;
    chk("R8 eoi then served", int'(run_id), 1023);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_nest_pop();
    t_deep_unlink();
    t_mid_unlink();
    t_eoi_ignored();
    t_repend();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule